// File: doc/BRIEF.md
# Floating-Point Cluster Latency Scheduler

This block models the timing of a floating-point execution cluster that sits behind a single dispatch port. The cluster holds four units: an adder and a multiplier, both fully pipelined, and a divider and a square-root unit, which are not pipelined. No arithmetic is done here. Each issued operation carries only a tag. The block returns that tag on a single writeback port in the cycle when the real unit would have produced its result.

A dispatcher offers one operation per cycle with a 2-bit opcode, a 2-bit precision code and a tag. The block answers in the same cycle with `issue_ready`, and the operation is taken when `issue_valid` and `issue_ready` are both high. The ready answer has two sources:

- A result-slot reservation register refuses an add or multiply whose result would land in a cycle already claimed by the other pipelined unit.
- The busy flags refuse a new divide or square root while that unit is still occupied.

Divides and square roots run alongside adds and multiplies. They compete only for the writeback port, and there they yield to pipelined results.

Top module: `fp_cluster_sched`

## Requirements
- R1: An add (opcode 0) accepted in cycle c shows `wb_valid` high in cycle c+3, with its tag and `wb_unit` = 0.
- R2: A multiply (opcode 1) accepted in cycle c shows `wb_valid` high in cycle c+5, with its tag and `wb_unit` = 1.
- R3: A divide (opcode 2) accepted in cycle c writes back in cycle c+L, with `wb_unit` = 2, whenever the port is free that cycle. L is 18 for precision code 0 (single), 27 for code 1 (double) and 36 for codes 2 and 3 (extended).
- R4: A square root (opcode 3) accepted in cycle c writes back in cycle c+L, with `wb_unit` = 3, whenever the port is free that cycle. L is 29 for precision code 0, 49 for code 1 and 69 for codes 2 and 3.
- R5: `div_busy` (or `sqrt_busy`) is high from the cycle after its operation is accepted up to and including the cycle that operation writes back, and low otherwise. While it is high, `issue_ready` is low for that opcode.
- R6: An add offered in the cycle two cycles after an accepted multiply is refused (`issue_ready` low), because both results would need the same writeback cycle. In all other cases an add or multiply is accepted, so the adder and multiplier never complete in the same cycle.
- R7: A pipelined result always takes the writeback port. A finished divide or square root holds its result, and `wb_valid` stays off for it, until a cycle with no pipelined result. If both iterative units are waiting, the divide goes first.
- R8: At most one result leaves per cycle, and every accepted operation writes back exactly once. `wb_valid` is low in any cycle where nothing is due.
- R9: During reset and in the first cycle after it, `wb_valid`, `div_busy` and `sqrt_busy` are low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation offered this cycle |
| issue_op | input | 2 | 0 add, 1 multiply, 2 divide, 3 square root |
| issue_prec | input | 2 | 0 single, 1 double, 2 or 3 extended |
| issue_tag | input | TAG_W | Tag carried to writeback |
| issue_ready | output | 1 | Offered operation can be accepted this cycle |
| div_busy | output | 1 | Divider occupied |
| sqrt_busy | output | 1 | Square-root unit occupied |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_unit | output | 2 | Unit of the result, same code as the opcode |
| wb_tag | output | TAG_W | Tag of the result |

## Verification
The hardest situation to reach is an iterative result that becomes ready while pipelined results are streaming out, because it forces the hold path. A close second is a divide and a square root becoming ready in the very same cycle. Directed sequences create both. One issues a single-precision divide and then issues an add in every cycle across its completion window. The other starts a square root and follows it 11 cycles later with a divide, so that both are ready together. A directed multiply-then-add pair probes the slot clash. Long random runs then mix all four opcodes and precisions against a cycle-by-cycle reference model.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2,
    OP_SQRT = 2'd3
  } fpc_op_e;

  // Latency of an iterative unit picked by precision code; codes 2 and 3 share extended.
  function automatic int unsigned iter_latency(
    input logic [1:0]  prec,
    input int unsigned lat_single,
    input int unsigned lat_double,
    input int unsigned lat_ext
  );
    case (prec)
      2'd0:    return lat_single;
      2'd1:    return lat_double;
      default: return lat_ext;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpc_tag_pipe.sv
module fpc_tag_pipe #(
  parameter int unsigned LAT   = 3,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);

  logic [LAT-1:0]   stg_v;
  logic [TAG_W-1:0] stg_t [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= '0;
    end else begin
      stg_v[0] <= in_valid;
      for (int i = 1; i < LAT; i++) stg_v[i] <= stg_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_t[0] <= in_tag;
    for (int i = 1; i < LAT; i++) stg_t[i] <= stg_t[i-1];
  end

  assign out_valid = stg_v[LAT-1];
  assign out_tag   = stg_t[LAT-1];

endmodule

// File: rtl/fpc_slot_resv.sv
module fpc_slot_resv #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] req_lat,   // cycles from issue to writeback, 2..DEPTH
  input  logic          claim,
  output logic          taken
);

  // resv[i] set: writeback slot i+1 cycles from now is already claimed
  logic [DEPTH-1:0] resv;
  logic [DEPTH-1:0] resv_next;
  logic [LW-1:0]    look_idx;
  logic [LW-1:0]    mark_idx;

  assign look_idx = req_lat - LW'(1);
  assign mark_idx = req_lat - LW'(2);
  assign taken    = resv[look_idx];

  always_comb begin
    resv_next = resv >> 1;
    if (claim) resv_next[mark_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resv <= '0;
    else        resv <= resv_next;
  end

endmodule

// File: rtl/fpc_iter_unit.sv
module fpc_iter_unit
  import fpc_pkg::*;
#(
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned LAT_SINGLE = 18,
  parameter int unsigned LAT_DOUBLE = 27,
  parameter int unsigned LAT_EXT    = 36,
  localparam int unsigned CW        = $clog2(LAT_EXT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       prec,
  input  logic [TAG_W-1:0] tag,
  input  logic             grant,
  output logic             busy,
  output logic             ready,
  output logic [TAG_W-1:0] res_tag
);

  logic [CW-1:0] remain;
  logic [CW-1:0] load_val;

  assign load_val = CW'(iter_latency(prec, LAT_SINGLE, LAT_DOUBLE, LAT_EXT) - 1);
  assign ready    = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= load_val;
    end else if (busy) begin
      if (remain != '0)  remain <= remain - CW'(1);
      else if (grant)    busy   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !busy) res_tag <= tag;
  end

endmodule

// File: rtl/fp_cluster_sched.sv
module fp_cluster_sched
  import fpc_pkg::*;
#(
  parameter int unsigned TAG_W       = 8,
  parameter int unsigned ADD_LAT     = 3,
  parameter int unsigned MUL_LAT     = 5,
  parameter int unsigned DIV_LAT_S   = 18,
  parameter int unsigned DIV_LAT_D   = 27,
  parameter int unsigned DIV_LAT_X   = 36,
  parameter int unsigned SQRT_LAT_S  = 29,
  parameter int unsigned SQRT_LAT_D  = 49,
  parameter int unsigned SQRT_LAT_X  = 69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [1:0]       issue_op,
  input  logic [1:0]       issue_prec,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             issue_ready,
  output logic             div_busy,
  output logic             sqrt_busy,
  output logic             wb_valid,
  output logic [1:0]       wb_unit,
  output logic [TAG_W-1:0] wb_tag
);

  localparam int unsigned RESV_D = max2(ADD_LAT, MUL_LAT);
  localparam int unsigned LW     = $clog2(RESV_D + 1);

  fpc_op_e op;
  assign op = fpc_op_e'(issue_op);

  // Named internal events
  logic             slot_taken;
  logic [LW-1:0]    pipe_lat;
  logic             acc_add, acc_mul, acc_div, acc_sqrt;
  logic             add_out_v, mul_out_v;
  logic [TAG_W-1:0] add_out_t, mul_out_t;
  logic             div_ready, sqrt_ready;
  logic [TAG_W-1:0] div_tag, sqrt_tag;
  logic             pipe_hit, div_grant, sqrt_grant;

  assign pipe_lat = (op == OP_MUL) ? LW'(MUL_LAT) : LW'(ADD_LAT);

  always_comb begin
    case (op)
      OP_ADD, OP_MUL: issue_ready = !slot_taken;
      OP_DIV:         issue_ready = !div_busy;
      default:        issue_ready = !sqrt_busy;
    endcase
  end

  assign acc_add  = issue_valid && issue_ready && (op == OP_ADD);
  assign acc_mul  = issue_valid && issue_ready && (op == OP_MUL);
  assign acc_div  = issue_valid && issue_ready && (op == OP_DIV);
  assign acc_sqrt = issue_valid && issue_ready && (op == OP_SQRT);

  fpc_slot_resv #(.DEPTH(RESV_D)) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_lat (pipe_lat),
    .claim   (acc_add || acc_mul),
    .taken   (slot_taken)
  );

  fpc_tag_pipe #(.LAT(ADD_LAT), .TAG_W(TAG_W)) u_add (
    .clk (clk), .rst_n (rst_n),
    .in_valid (acc_add), .in_tag (issue_tag),
    .out_valid (add_out_v), .out_tag (add_out_t)
  );

  fpc_tag_pipe #(.LAT(MUL_LAT), .TAG_W(TAG_W)) u_mul (
    .clk (clk), .rst_n (rst_n),
    .in_valid (acc_mul), .in_tag (issue_tag),
    .out_valid (mul_out_v), .out_tag (mul_out_t)
  );

  fpc_iter_unit #(
    .TAG_W(TAG_W), .LAT_SINGLE(DIV_LAT_S), .LAT_DOUBLE(DIV_LAT_D), .LAT_EXT(DIV_LAT_X)
  ) u_div (
    .clk (clk), .rst_n (rst_n),
    .start (acc_div), .prec (issue_prec), .tag (issue_tag),
    .grant (div_grant),
    .busy (div_busy), .ready (div_ready), .res_tag (div_tag)
  );

  fpc_iter_unit #(
    .TAG_W(TAG_W), .LAT_SINGLE(SQRT_LAT_S), .LAT_DOUBLE(SQRT_LAT_D), .LAT_EXT(SQRT_LAT_X)
  ) u_sqrt (
    .clk (clk), .rst_n (rst_n),
    .start (acc_sqrt), .prec (issue_prec), .tag (issue_tag),
    .grant (sqrt_grant),
    .busy (sqrt_busy), .ready (sqrt_ready), .res_tag (sqrt_tag)
  );

  // Writeback arbitration: pipelined first, then divide, then square root
  assign pipe_hit   = add_out_v || mul_out_v;
  assign div_grant  = div_ready && !pipe_hit;
  assign sqrt_grant = sqrt_ready && !pipe_hit && !div_ready;
  assign wb_valid   = pipe_hit || div_ready || sqrt_ready;

  always_comb begin
    if (add_out_v) begin
      wb_unit = OP_ADD;  wb_tag = add_out_t;
    end else if (mul_out_v) begin
      wb_unit = OP_MUL;  wb_tag = mul_out_t;
    end else if (div_ready) begin
      wb_unit = OP_DIV;  wb_tag = div_tag;
    end else begin
      wb_unit = OP_SQRT; wb_tag = sqrt_tag;
    end
  end

endmodule

// File: rtl/fpc_sched_checker.sv
module fpc_sched_checker #(
  parameter int unsigned ADD_LAT = 3,
  parameter int unsigned MUL_LAT = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_add,
  input logic       acc_mul,
  input logic       acc_div,
  input logic       acc_sqrt,
  input logic       add_out_v,
  input logic       mul_out_v,
  input logic       div_ready,
  input logic       sqrt_ready,
  input logic       div_grant,
  input logic       sqrt_grant,
  input logic       div_busy,
  input logic       sqrt_busy,
  input logic       wb_valid,
  input logic [1:0] wb_unit
);

  AST_ADD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |-> ##ADD_LAT (add_out_v && wb_valid && wb_unit == 2'd0)); // R1

  AST_MUL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul |-> ##MUL_LAT (mul_out_v && wb_valid)); // R2

  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_div |-> (!div_busy ##1 div_busy)); // R5

  AST_SQRT_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sqrt |-> (!sqrt_busy ##1 sqrt_busy)); // R5

  AST_DIV_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_grant) |=> div_busy); // R5

  AST_NO_PIPE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_out_v && mul_out_v)); // R6

  AST_PIPE_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (add_out_v || mul_out_v) |-> !(div_grant || sqrt_grant)); // R7

  AST_DIV_BEFORE_SQRT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ready && sqrt_ready) |-> !sqrt_grant); // R7

  AST_HELD_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sqrt_ready && !sqrt_grant) |=> sqrt_ready); // R7

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({div_grant, sqrt_grant}) <= 1); // R8

endmodule

bind fp_cluster_sched fpc_sched_checker #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_add    (acc_add),
  .acc_mul    (acc_mul),
  .acc_div    (acc_div),
  .acc_sqrt   (acc_sqrt),
  .add_out_v  (add_out_v),
  .mul_out_v  (mul_out_v),
  .div_ready  (div_ready),
  .sqrt_ready (sqrt_ready),
  .div_grant  (div_grant),
  .sqrt_grant (sqrt_grant),
  .div_busy   (div_busy),
  .sqrt_busy  (sqrt_busy),
  .wb_valid   (wb_valid),
  .wb_unit    (wb_unit)
);

// File: tb/fp_cluster_sched_test.sv
module fp_cluster_sched_test;

  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0;
  logic [1:0]       issue_op = 2'd0;
  logic [1:0]       issue_prec = 2'd0;
  logic [TAG_W-1:0] issue_tag = '0;
  logic             issue_ready, div_busy, sqrt_busy, wb_valid;
  logic [1:0]       wb_unit;
  logic [TAG_W-1:0] wb_tag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_cluster_sched uut (
    .clk (clk), .rst_n (rst_n),
    .issue_valid (issue_valid), .issue_op (issue_op),
    .issue_prec (issue_prec), .issue_tag (issue_tag),
    .issue_ready (issue_ready), .div_busy (div_busy), .sqrt_busy (sqrt_busy),
    .wb_valid (wb_valid), .wb_unit (wb_unit), .wb_tag (wb_tag)
  );

  // Reference model state
  int         cyc = 0;
  bit         cal_v [8];
  logic [1:0] cal_u [8];
  logic [7:0] cal_t [8];
  bit         dv_act = 0, sq_act = 0;
  int         dv_rdy = 0, sq_rdy = 0;
  logic [7:0] dv_tag = '0, sq_tag = '0;

  function automatic int div_lat(input logic [1:0] p);
    if (p == 2'd0) return 18;
    if (p == 2'd1) return 27;
    return 36;
  endfunction

  function automatic int sqrt_lat(input logic [1:0] p);
    if (p == 2'd0) return 29;
    if (p == 2'd1) return 49;
    return 69;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // One cycle: drive, compare against the model, advance the model
  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] pr, input logic [7:0] tg);
    bit         e_v;
    logic [1:0] e_u;
    logic [7:0] e_t;
    bit         e_rdy;
    string      req;
    int         slot;
    @(negedge clk);
    issue_valid = v; issue_op = op; issue_prec = pr; issue_tag = tg;
    #1;
    slot = cyc % 8;
    e_v = 0; e_u = 0; e_t = 0; req = "R8";
    if (cal_v[slot]) begin
      e_v = 1; e_u = cal_u[slot]; e_t = cal_t[slot];
      req = (e_u == 2'd0) ? "R1" : "R2";
    end else if (dv_act && cyc >= dv_rdy) begin
      e_v = 1; e_u = 2'd2; e_t = dv_tag;
      req = (cyc > dv_rdy) ? "R7" : "R3";
    end else if (sq_act && cyc >= sq_rdy) begin
      e_v = 1; e_u = 2'd3; e_t = sq_tag;
      req = (cyc > sq_rdy) ? "R7" : "R4";
    end
    check(req, "wb_valid", int'(wb_valid), int'(e_v));
    if (e_v) begin
      check(req, "wb_unit", int'(wb_unit), int'(e_u));
      check(req, "wb_tag", int'(wb_tag), int'(e_t));
    end
    check("R5", "div_busy", int'(div_busy), int'(dv_act));
    check("R5", "sqrt_busy", int'(sqrt_busy), int'(sq_act));
    case (op)
      2'd0:    e_rdy = !cal_v[(cyc + 3) % 8];
      2'd1:    e_rdy = !cal_v[(cyc + 5) % 8];
      2'd2:    e_rdy = !dv_act;
      default: e_rdy = !sq_act;
    endcase
    check((op < 2) ? "R6" : "R5", "issue_ready", int'(issue_ready), int'(e_rdy));
    // retire what left this cycle
    if (cal_v[slot]) cal_v[slot] = 0;
    else if (e_v && e_u == 2'd2) dv_act = 0;
    else if (e_v && e_u == 2'd3) sq_act = 0;
    // accept
    if (v && e_rdy) begin
      case (op)
        2'd0: begin cal_v[(cyc+3)%8] = 1; cal_u[(cyc+3)%8] = 2'd0; cal_t[(cyc+3)%8] = tg; end
        2'd1: begin cal_v[(cyc+5)%8] = 1; cal_u[(cyc+5)%8] = 2'd1; cal_t[(cyc+5)%8] = tg; end
        2'd2: begin dv_act = 1; dv_rdy = cyc + div_lat(pr); dv_tag = tg; end
        default: begin sq_act = 1; sq_rdy = cyc + sqrt_lat(pr); sq_tag = tg; end
      endcase
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 2'd0, 8'd0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin cal_v[i] = 0; cal_u[i] = 0; cal_t[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R9: quiet during reset
    check("R9", "wb_valid in reset", int'(wb_valid), 0);
    check("R9", "div_busy in reset", int'(div_busy), 0);
    check("R9", "sqrt_busy in reset", int'(sqrt_busy), 0);
    check("R9", "issue_ready in reset", int'(issue_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R3 / R4: every precision code, divide and square root
    for (int p = 0; p < 4; p++) begin
      step(1, 2'd2, 2'(p), 8'(8'h10 + p));
      step(1, 2'd3, 2'(p), 8'(8'h20 + p));
      idle(72);
    end

    // R6: multiply then add two cycles later collides
    step(1, 2'd1, 2'd0, 8'h31);
    step(0, 2'd0, 2'd0, 8'h00);
    step(1, 2'd0, 2'd0, 8'h32);
    step(1, 2'd0, 2'd0, 8'h33);
    idle(8);

    // R7: divide finishing while adds stream every cycle
    step(1, 2'd2, 2'd0, 8'h41);
    idle(13);
    for (int i = 0; i < 8; i++) step(1, 2'd0, 2'd0, 8'(8'h50 + i));
    idle(30);

    // R7: divide and square root ready in the same cycle
    step(1, 2'd3, 2'd0, 8'h61);
    idle(10);
    step(1, 2'd2, 2'd0, 8'h62);
    idle(40);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      bit         v;
      logic [1:0] o, p;
      v = ($urandom % 10) < 7;
      o = 2'($urandom % 4);
      p = 2'($urandom % 4);
      step(v, o, p, 8'($urandom));
    end
    idle(100);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule